// File: doc/BRIEF.md
# Per-processor private interrupt arbiter

This block keeps the private peripheral interrupts of several processors, numbered 16 to 31, apart from any shared interrupt logic. Each processor owns a 16-bit pending vector and a 16-bit active vector, where bit k stands for interrupt 16+k. A peripheral raises an interrupt with a one-cycle pulse that carries the interrupt number and the target processor. Only that processor's pending bit changes.

For every processor the block presents the most urgent pending interrupt as the best candidate, using that processor's own bank of priorities. The processor acknowledges the candidate, which moves it from pending to active. It later retires the interrupt with an end-of-interrupt request that names it. A registered running priority reports the most urgent priority among the processor's active interrupts. A processor whose interface is disabled keeps its running priority frozen.

There is no state machine in the per-processor path. An end-of-interrupt request is classified as none, retire or stray, and a stray request raises an error pulse.

Top module: `priv_irq_arbiter`

## Requirements
- R1: After reset, every pending and active bit is clear. Each processor's `sel_id` reads 1023 (spurious), `sel_prio` and `run_prio` read 0xFF, and `eoi_err` is 0.
- R2: A pulse on `irq_valid` with `irq_num` in 16..31 and `irq_cpu` naming processor c sets pending bit (irq_num-16) of processor c only, at the next edge. A pulse whose number lies outside 16..31 changes nothing.
- R3: For each processor, `sel_id`/`sel_prio` show the pending interrupt with the numerically smallest priority. On equal priority the lowest number wins. A pending interrupt whose priority is 0xFF is never selected. With no selectable interrupt the outputs read 1023 and 0xFF. The selection follows the registered state and the current priority bank without a further register.
- R4: The priority of interrupt 16+k for processor c is `prio_bank[(c*16+k)*8 +: 8]` (default widths). Each processor's selection and running priority use only its own bank.
- R5: `ack_req[c]` with a selectable candidate sets that candidate's active bit and clears its pending bit at the edge. `ack_req[c]` with no candidate has no effect.
- R6: `eoi_req[c]` with `eoi_id` slice c in 16..31 clears that active bit. If the bit was not active, `eoi_err[c]` is 1 for exactly the cycle after the request. An `eoi_id` outside 16..31 has no effect and raises no error.
- R7: `run_prio[c]` is the smallest priority among processor c's active interrupts, or 0xFF when none is active. It takes the new value at the same edge that commits an acknowledge or end-of-interrupt.
- R8: While `cpu_enable[c]` is 0, `run_prio[c]` holds its value, while acknowledge and end-of-interrupt still change the vectors. It catches up at the first edge after re-enable.
- R9: An assertion of interrupt n and an acknowledge that takes n, in the same cycle on the same processor, leave n both active and pending.
- R10: When an acknowledge and an end-of-interrupt fall in the same cycle, the end-of-interrupt is judged against the active vector before the edge, and the acknowledge's active bit is applied after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_valid | input | 1 | Peripheral assertion pulse |
| irq_num | input | ID_W | Interrupt number of the assertion |
| irq_cpu | input | CPU_W | Target processor of the assertion |
| cpu_enable | input | NCPU | Per-processor interface enable |
| prio_bank | input | NCPU*NPRIV*PRIO_W | Banked priorities, processor-major |
| ack_req | input | NCPU | Acknowledge the current candidate |
| eoi_req | input | NCPU | End-of-interrupt request |
| eoi_id | input | NCPU*ID_W | Interrupt number retired by each processor |
| sel_id | output | NCPU*ID_W | Best candidate number, 1023 if none |
| sel_prio | output | NCPU*PRIO_W | Best candidate priority, 0xFF if none |
| run_prio | output | NCPU*PRIO_W | Registered running priority |
| eoi_err | output | NCPU | End-of-interrupt on an inactive interrupt |

## Verification
Two functions can meet in one cycle on one processor: a fresh assertion of an interrupt can arrive while the processor acknowledges that same interrupt. The bench provokes this by asserting a lone interrupt, then re-asserting it in the cycle that carries the acknowledge. It judges the result by the candidate output, which must still name the interrupt, and by the running priority, which must already show it as active. The same approach pairs an acknowledge with an end-of-interrupt for the same, not yet active, number. There the error pulse must fire and the interrupt must end active.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int unsigned PRIV_BASE   = 16;
    localparam int unsigned SPURIOUS_ID = 1023;

    typedef enum logic [1:0] {
        EOI_NONE,
        EOI_RETIRE,
        EOI_STRAY
    } eoi_kind_e;
endpackage

// File: rtl/pirq_pick.sv
// Argmin over a masked priority vector, ascending scan, strict improvement.
module pirq_pick #(
    parameter int N  = 16,
    parameter int PW = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    mask,
    input  logic [N*PW-1:0] prios,
    output logic [IW-1:0]   idx,
    output logic [PW-1:0]   best
);
    always_comb begin
        best = '1;
        idx  = '0;
        for (int i = 0; i < N; i++) begin
            if (mask[i] && (prios[i*PW +: PW] < best)) begin
                best = prios[i*PW +: PW];
                idx  = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pirq_min.sv
// Minimum priority over a masked vector; all-ones when the mask is empty.
module pirq_min #(
    parameter int N  = 16,
    parameter int PW = 8
) (
    input  logic [N-1:0]    mask,
    input  logic [N*PW-1:0] prios,
    output logic [PW-1:0]   best
);
    always_comb begin
        best = '1;
        for (int i = 0; i < N; i++) begin
            if (mask[i] && (prios[i*PW +: PW] < best))
                best = prios[i*PW +: PW];
        end
    end
endmodule

// File: rtl/pirq_slice.sv
// State and arbitration for one processor.
module pirq_slice
    import pirq_pkg::*;
#(
    parameter int N   = 16,
    parameter int PW  = 8,
    parameter int IDW = 10,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    set_vec,
    input  logic            ack,
    input  logic            eoi,
    input  logic [IDW-1:0]  eoi_id,
    input  logic            enable,
    input  logic [N*PW-1:0] prios,
    output logic [IDW-1:0]  sel_id,
    output logic [PW-1:0]   sel_prio,
    output logic [PW-1:0]   run_prio,
    output logic            eoi_err
);
    logic [N-1:0]   pend_q, act_q, pend_d, act_d;
    logic [N-1:0]   ack_set, eoi_clr;
    logic [IW-1:0]  pick_idx, eoi_idx;
    logic [PW-1:0]  pick_best, run_min, run_q;
    logic [IDW-1:0] eoi_off;
    logic           hit, eoi_in_rng, err_q;
    eoi_kind_e      eoi_kind;

    pirq_pick #(.N(N), .PW(PW)) u_pick (
        .mask  (pend_q),
        .prios (prios),
        .idx   (pick_idx),
        .best  (pick_best)
    );

    // A candidate exists exactly when the scan improved on all-ones.
    assign hit = (pick_best != {PW{1'b1}});

    assign eoi_off    = eoi_id - IDW'(PRIV_BASE);
    assign eoi_in_rng = (eoi_id >= IDW'(PRIV_BASE)) && (eoi_off < IDW'(N));
    assign eoi_idx    = eoi_off[IW-1:0];

    always_comb begin
        if (!eoi || !eoi_in_rng)
            eoi_kind = EOI_NONE;
        else if (act_q[eoi_idx])
            eoi_kind = EOI_RETIRE;
        else
            eoi_kind = EOI_STRAY;
    end

    always_comb begin
        ack_set = '0;
        eoi_clr = '0;
        if (ack && hit)
            ack_set[pick_idx] = 1'b1;
        unique case (eoi_kind)
            EOI_NONE:              eoi_clr = '0;
            EOI_RETIRE, EOI_STRAY: eoi_clr[eoi_idx] = 1'b1;
            default:               eoi_clr = '0;
        endcase
        // A new assertion wins over the acknowledge clearing the same bit.
        pend_d = (pend_q & ~ack_set) | set_vec;
        // End-of-interrupt uses the pre-edge active vector; acknowledge applies after.
        act_d  = (act_q & ~eoi_clr) | ack_set;
    end

    pirq_min #(.N(N), .PW(PW)) u_run (
        .mask  (act_d),
        .prios (prios),
        .best  (run_min)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            act_q  <= '0;
            run_q  <= '1;
            err_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            act_q  <= act_d;
            if (enable)
                run_q <= run_min;
            err_q  <= (eoi_kind == EOI_STRAY);
        end
    end

    assign sel_id   = hit ? (IDW'(PRIV_BASE) + IDW'(pick_idx)) : IDW'(SPURIOUS_ID);
    assign sel_prio = pick_best;
    assign run_prio = run_q;
    assign eoi_err  = err_q;
endmodule

// File: rtl/priv_irq_arbiter.sv
module priv_irq_arbiter
    import pirq_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int NPRIV  = 16,
    parameter int PRIO_W = 8,
    parameter int ID_W   = 10,
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int PIW   = (NPRIV > 1) ? $clog2(NPRIV) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      irq_valid,
    input  logic [ID_W-1:0]           irq_num,
    input  logic [CPU_W-1:0]          irq_cpu,
    input  logic [NCPU-1:0]           cpu_enable,
    input  logic [NCPU*NPRIV*PRIO_W-1:0] prio_bank,
    input  logic [NCPU-1:0]           ack_req,
    input  logic [NCPU-1:0]           eoi_req,
    input  logic [NCPU*ID_W-1:0]      eoi_id,
    output logic [NCPU*ID_W-1:0]      sel_id,
    output logic [NCPU*PRIO_W-1:0]    sel_prio,
    output logic [NCPU*PRIO_W-1:0]    run_prio,
    output logic [NCPU-1:0]           eoi_err
);
    localparam int BANK_W = NPRIV * PRIO_W;

    logic [ID_W-1:0] irq_off;
    logic            irq_in_rng;
    logic [PIW-1:0]  irq_idx;

    assign irq_off    = irq_num - ID_W'(PRIV_BASE);
    assign irq_in_rng = (irq_num >= ID_W'(PRIV_BASE)) && (irq_off < ID_W'(NPRIV));
    assign irq_idx    = irq_off[PIW-1:0];

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [NPRIV-1:0] set_vec;

        always_comb begin
            set_vec = '0;
            if (irq_valid && irq_in_rng && (irq_cpu == CPU_W'(c)))
                set_vec[irq_idx] = 1'b1;
        end

        pirq_slice #(.N(NPRIV), .PW(PRIO_W), .IDW(ID_W)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_vec  (set_vec),
            .ack      (ack_req[c]),
            .eoi      (eoi_req[c]),
            .eoi_id   (eoi_id[c*ID_W +: ID_W]),
            .enable   (cpu_enable[c]),
            .prios    (prio_bank[c*BANK_W +: BANK_W]),
            .sel_id   (sel_id[c*ID_W +: ID_W]),
            .sel_prio (sel_prio[c*PRIO_W +: PRIO_W]),
            .run_prio (run_prio[c*PRIO_W +: PRIO_W]),
            .eoi_err  (eoi_err[c])
        );
    end
endmodule

// File: rtl/pirq_chk.sv
module pirq_chk
    import pirq_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int NPRIV  = 16,
    parameter int PRIO_W = 8,
    parameter int ID_W   = 10
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NCPU-1:0]        cpu_enable,
    input logic [NCPU-1:0]        ack_req,
    input logic [NCPU-1:0]        eoi_req,
    input logic [NCPU*ID_W-1:0]   eoi_id,
    input logic [NCPU*ID_W-1:0]   sel_id,
    input logic [NCPU*PRIO_W-1:0] sel_prio,
    input logic [NCPU*PRIO_W-1:0] run_prio,
    input logic [NCPU-1:0]        eoi_err
);
    for (genvar c = 0; c < NCPU; c++) begin : g_chk
        logic [ID_W-1:0]   sid, eid;
        logic [PRIO_W-1:0] spr, rpr;
        logic              eid_ok, sid_ok;

        assign sid    = sel_id[c*ID_W +: ID_W];
        assign eid    = eoi_id[c*ID_W +: ID_W];
        assign spr    = sel_prio[c*PRIO_W +: PRIO_W];
        assign rpr    = run_prio[c*PRIO_W +: PRIO_W];
        assign eid_ok = (eid >= ID_W'(PRIV_BASE)) && (eid < ID_W'(PRIV_BASE + NPRIV));
        assign sid_ok = (sid >= ID_W'(PRIV_BASE)) && (sid < ID_W'(PRIV_BASE + NPRIV));

        // R6
        err_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            eoi_err[c] |-> $past(eoi_req[c]));

        // R6
        eoi_out_of_range_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (eoi_req[c] && !eid_ok) |=> !eoi_err[c]);

        // R3
        spurious_idle_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sid == ID_W'(SPURIOUS_ID)) |-> (spr == {PRIO_W{1'b1}}));

        // R3
        candidate_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sid != ID_W'(SPURIOUS_ID)) |-> (sid_ok && (spr != {PRIO_W{1'b1}})));

        // R8
        frozen_run_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cpu_enable[c] |=> $stable(rpr));

        // R7
        ack_lifts_run_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_req[c] && cpu_enable[c] && (sid != ID_W'(SPURIOUS_ID)))
                |=> (rpr <= $past(spr)));
    end
endmodule

bind priv_irq_arbiter pirq_chk #(
    .NCPU   (NCPU),
    .NPRIV  (NPRIV),
    .PRIO_W (PRIO_W),
    .ID_W   (ID_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_enable (cpu_enable),
    .ack_req    (ack_req),
    .eoi_req    (eoi_req),
    .eoi_id     (eoi_id),
    .sel_id     (sel_id),
    .sel_prio   (sel_prio),
    .run_prio   (run_prio),
    .eoi_err    (eoi_err)
);

// File: tb/sim_priv_irq_arbiter.sv
`timescale 1ns/1ps
module sim_priv_irq_arbiter;
    localparam int NC = 4;
    localparam int NP = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          irq_valid;
    logic [9:0]    irq_num;
    logic [1:0]    irq_cpu;
    logic [3:0]    en, ack, eoi;
    logic [39:0]   eoi_bus;
    logic [511:0]  bank;
    logic [39:0]   sel_id;
    logic [31:0]   sel_prio, run_prio;
    logic [3:0]    eoi_err;

    logic [15:0]   m_pend [NC];
    logic [15:0]   m_act  [NC];
    logic [7:0]    m_prio [NC][NP];
    logic [7:0]    m_run  [NC];
    logic [3:0]    m_err;
    int            e_id   [NC];
    int            n_tests = 0;
    int            n_fail  = 0;

    always #10 clk = ~clk;

    priv_irq_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_num(irq_num),
        .irq_cpu(irq_cpu), .cpu_enable(en), .prio_bank(bank), .ack_req(ack),
        .eoi_req(eoi), .eoi_id(eoi_bus), .sel_id(sel_id), .sel_prio(sel_prio),
        .run_prio(run_prio), .eoi_err(eoi_err)
    );

    function automatic int exp_idx(int c);
        int b = 255;
        int r = -1;
        for (int k = 0; k < NP; k++)
            if (m_pend[c][k] && (int'(m_prio[c][k]) < b)) begin
                b = int'(m_prio[c][k]);
                r = k;
            end
        return r;
    endfunction

    function automatic int exp_min(int c, logic [15:0] a);
        int b = 255;
        for (int k = 0; k < NP; k++)
            if (a[k] && (int'(m_prio[c][k]) < b)) b = int'(m_prio[c][k]);
        return b;
    endfunction

    task automatic chk(string tag, int c, string what, int act_v, int exp_v);
        n_tests++;
        if (act_v != exp_v) begin
            n_fail++;
            $display("FAIL %s cpu%0d %s: actual %0d expected %0d", tag, c, what, act_v, exp_v);
        end
    endtask

    task automatic check_all(string tag);
        for (int c = 0; c < NC; c++) begin
            int i = exp_idx(c);
            chk(tag, c, "sel_id", int'(sel_id[c*10 +: 10]), (i < 0) ? 1023 : 16 + i);
            chk(tag, c, "sel_prio", int'(sel_prio[c*8 +: 8]), (i < 0) ? 255 : int'(m_prio[c][i]));
            chk(tag, c, "run_prio", int'(run_prio[c*8 +: 8]), int'(m_run[c]));
            chk(tag, c, "eoi_err", int'(eoi_err[c]), int'(m_err[c]));
        end
    endtask

    task automatic load_bus();
        for (int c = 0; c < NC; c++) begin
            eoi_bus[c*10 +: 10] = 10'(e_id[c]);
            for (int k = 0; k < NP; k++) bank[(c*NP + k)*8 +: 8] = m_prio[c][k];
        end
    endtask

    // One clock with the currently driven inputs, model update, then checks.
    task automatic step(string tag);
        logic [15:0] np [NC];
        logic [15:0] na [NC];
        logic [3:0]  ne;
        load_bus();
        ne = '0;
        for (int c = 0; c < NC; c++) begin
            int s = exp_idx(c);
            logic [15:0] aset = '0;
            logic [15:0] sset = '0;
            logic [15:0] eclr = '0;
            if (ack[c] && s >= 0) aset[s] = 1'b1;
            if (irq_valid && irq_num >= 16 && irq_num < 32 && int'(irq_cpu) == c)
                sset[irq_num - 16] = 1'b1;
            if (eoi[c] && e_id[c] >= 16 && e_id[c] < 32) begin
                if (!m_act[c][e_id[c] - 16]) ne[c] = 1'b1;
                eclr[e_id[c] - 16] = 1'b1;
            end
            np[c] = (m_pend[c] & ~aset) | sset;
            na[c] = (m_act[c] & ~eclr) | aset;
        end
        @(posedge clk);
        for (int c = 0; c < NC; c++) begin
            m_pend[c] = np[c];
            m_act[c]  = na[c];
            if (en[c]) m_run[c] = 8'(exp_min(c, na[c]));
        end
        m_err = ne;
        @(negedge clk);
        irq_valid = 1'b0;
        ack = '0;
        eoi = '0;
        check_all(tag);
    endtask

    task automatic fire(int c, int n, string tag);
        irq_valid = 1'b1; irq_num = 10'(n); irq_cpu = 2'(c);
        step(tag);
    endtask

    task automatic do_ack(int c, string tag);
        ack[c] = 1'b1;
        step(tag);
    endtask

    task automatic do_eoi(int c, int n, string tag);
        eoi[c] = 1'b1; e_id[c] = n;
        step(tag);
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; irq_valid = 1'b0; irq_num = '0; irq_cpu = '0;
        en = 4'hF; ack = '0; eoi = '0; m_err = '0;
        for (int c = 0; c < NC; c++) begin
            m_pend[c] = '0; m_act[c] = '0; m_run[c] = 8'hFF; e_id[c] = 0;
            for (int k = 0; k < NP; k++) m_prio[c][k] = 8'h80;
        end
        load_bus();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2 R4 R5 R6: every interrupt on every processor, distinct banks
        for (int c = 0; c < NC; c++)
            for (int k = 0; k < NP; k++) m_prio[c][k] = 8'((c*53 + k*29) % 255);
        for (int c = 0; c < NC; c++)
            for (int k = 0; k < NP; k++) begin
                fire(c, 16 + k, "R2");
                do_ack(c, "R5");
                do_eoi(c, 16 + k, "R6");
            end

        // R3 R7: tie-heavy priorities, drain by acknowledge, retire in reverse
        for (int c = 0; c < NC; c++)
            for (int k = 0; k < NP; k++) m_prio[c][k] = 8'(((k*7 + c*3) % 5) * 32);
        for (int c = 0; c < NC; c++) begin
            for (int k = 0; k < NP; k++) fire(c, 16 + k, "R3");
            for (int k = 0; k < NP; k++) do_ack(c, "R3");
            for (int k = NP - 1; k >= 0; k--) do_eoi(c, 16 + k, "R7");
        end

        // R3: priority 0xFF is not selectable; R4: bank change takes effect
        m_prio[0][3] = 8'hFF;
        fire(0, 19, "R3");
        m_prio[0][3] = 8'h10;
        step("R4");
        do_ack(0, "R5");
        do_eoi(0, 19, "R7");
        do_ack(0, "R5");

        // R2: out-of-range numbers are ignored
        fire(1, 15, "R2");
        fire(1, 32, "R2");
        fire(1, 1023, "R2");

        // R6: stray and out-of-range end-of-interrupt
        do_eoi(2, 20, "R6");
        step("R6");
        do_eoi(2, 5, "R6");

        // R8: disabled processor keeps running priority
        en[1] = 1'b0;
        fire(1, 18, "R8");
        do_ack(1, "R8");
        en[1] = 1'b1;
        step("R8");
        do_eoi(1, 18, "R8");

        // R9: assertion and acknowledge of the same interrupt together
        fire(3, 25, "R9");
        irq_valid = 1'b1; irq_num = 10'd25; irq_cpu = 2'd3; ack[3] = 1'b1;
        step("R9");
        do_ack(3, "R9");
        do_eoi(3, 25, "R9");

        // R10: acknowledge and end-of-interrupt of a not yet active number together
        fire(0, 17, "R10");
        ack[0] = 1'b1; eoi[0] = 1'b1; e_id[0] = 17;
        step("R10");
        do_eoi(0, 17, "R10");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule